// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital control section of a 12-bit successive-approximation converter. It watches a read/convert line. When that line falls while the part is enabled and selected, the block starts a conversion. The conversion begins with a fixed two-clock acquisition window, during which the sample switch is closed. The block then tests one bit per clock, from the most significant bit down to the least significant bit. A single comparator input decides whether each trial bit is kept. When the last bit is decided, the status output drops and the code becomes readable on a parallel bus.

The analog side is not part of this block. It appears only as three signals: the comparator input `cmp_below`, the trial code driven toward the capacitor DAC, and the sample-enable output. The result is a straight binary code. Whether that code is read as plain binary (unipolar ranges) or as offset binary (bipolar ranges, where the MSB is the inverse of the two's-complement sign) depends only on how the analog input is scaled. The digital sequence is the same in both cases.

The parallel read is a chip-select style bus and not a stream. `rd_oe` plays the part of a valid flag. There is no back-pressure, because a held result stays readable for as long as the bus keeps asking.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A conversion starts only when `rc_n` is sampled low on a clock edge after being sampled high on the previous edge, with `ce`=1 and `cs_n`=0 on that edge. `busy` is high from that edge on. A falling `rc_n` without both enables starts nothing.
- R2: On the start edge the trial register is cleared, so `trial_code` reads 0 while acquisition lasts.
- R3: `sample_en` is high for exactly the first two clocks after the start edge and low at all other times.
- R4: Bits are tried from bit 11 down to bit 0. During a trial, `trial_code` equals the bits already kept OR the one trial bit, so the first trial code is 12'h800. A trial bit is kept when `cmp_below`=1 and cleared when it is 0. With an ideal comparator (`cmp_below` = trial_code <= input) the result equals the input code.
- R5: In 12-bit mode (`short_mode`=0 at the start edge), `busy` stays high for exactly 2 + 12 = 14 clocks.
- R6: In 8-bit mode (`short_mode`=1 at the start edge), the conversion stops after the trial of bit 4. `busy` is high for exactly 10 clocks, and result bits 3:0 read 0.
- R7: Once a conversion has started, further falling edges on `rc_n` are ignored until `busy` drops. The conversion length and the result are unaffected.
- R8: `rd_oe` = `ce` & !`cs_n` & `rc_n` & !`busy`. `rd_data` carries the result when `rd_oe`=1 and reads 0 otherwise.
- R9: After reset `busy`=0, `sample_en`=0, and the held result is 0.
- R10: The result stays readable and unchanged, through any number of reads, until the next conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rc_n | input | 1 | Read/convert line: falling edge starts a conversion, high allows a read |
| ce | input | 1 | Chip enable, active high |
| cs_n | input | 1 | Chip select, active low |
| short_mode | input | 1 | 1 selects an 8-bit conversion, sampled at the start edge |
| cmp_below | input | 1 | Comparator: 1 when the trial level is at or below the input |
| trial_code | output | 12 | Code presented to the DAC |
| sample_en | output | 1 | Sample switch closed during acquisition |
| busy | output | 1 | Conversion status, high while converting |
| rd_data | output | 12 | Parallel result, zero when not enabled |
| rd_oe | output | 1 | Output enable for the data bus (high-impedance when 0) |

## Verification
The bound checker checks these properties on every cycle:
- a rise of `busy` was qualified by both enables;
- sampling happens only inside a conversion, and only with a zero trial code;
- the bus never enables while `busy` is high;
- the trial code holds still while idle;
- a conversion never runs longer than fourteen clocks.

Some behaviour only the bench scenarios can show:
- the exact bit decisions, measured by sweeping every 12-bit input code through an ideal comparator;
- the exact 14-clock and 10-clock status widths;
- that retrigger edges in mid-conversion leave both length and result unchanged;
- that reads are gated by each enable separately.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ACQ   = 2'd1,
    PH_TRIAL = 2'd2
  } phase_t;
endpackage

// File: rtl/sar_start_qual.sv
// Detects a qualified falling edge on the read/convert line while idle.
module sar_start_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic rc_n,
  input  logic ce,
  input  logic cs_n,
  input  logic idle,
  output logic start
);
  logic rc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rc_q <= 1'b1;
    else        rc_q <= rc_n;
  end

  // A falling edge during a conversion is dropped, not queued.
  assign start = idle & ce & ~cs_n & rc_q & ~rc_n;
endmodule

// File: rtl/sar_phase_seq.sv
// Phase sequencer: acquisition window, then one bit trial per clock.
module sar_phase_seq
  import sar_ctrl_pkg::*;
#(
  parameter int NBITS      = 12,
  parameter int SHORT_BITS = 8,
  parameter int ACQ_CYCLES = 2,
  localparam int IW = $clog2(NBITS),
  localparam int AW = $clog2(ACQ_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          short_mode,
  output phase_t        phase,
  output logic [IW-1:0] bit_idx,
  output logic          decide
);
  logic [AW-1:0] acq_cnt;
  logic          short_q;
  logic [IW-1:0] stop_idx;

  assign stop_idx = short_q ? IW'(NBITS - SHORT_BITS) : '0;
  assign decide   = (phase == PH_TRIAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      acq_cnt <= '0;
      bit_idx <= '0;
      short_q <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase   <= PH_ACQ;
          acq_cnt <= '0;
          short_q <= short_mode;
        end
        PH_ACQ: if (acq_cnt == AW'(ACQ_CYCLES - 1)) begin
          phase   <= PH_TRIAL;
          bit_idx <= IW'(NBITS - 1);
        end else begin
          acq_cnt <= acq_cnt + AW'(1);
        end
        PH_TRIAL: if (bit_idx == stop_idx) begin
          phase <= PH_IDLE;
        end else begin
          bit_idx <= bit_idx - IW'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_trial_reg.sv
// Trial/result register: one flop per bit, set by the comparator on its trial.
module sar_trial_reg #(
  parameter int NBITS = 12,
  localparam int IW = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             decide,
  input  logic [IW-1:0]    bit_idx,
  input  logic             cmp_below,
  output logic [NBITS-1:0] result,
  output logic [NBITS-1:0] trial_code
);
  logic [NBITS-1:0] probe;

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    assign probe[b] = decide & (bit_idx == IW'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        result[b] <= 1'b0;
      else if (clr)      result[b] <= 1'b0;
      else if (probe[b]) result[b] <= cmp_below;
    end
  end

  assign trial_code = result | probe;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_ctrl_pkg::*;
#(
  parameter int NBITS      = 12,
  parameter int SHORT_BITS = 8,
  parameter int ACQ_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rc_n,
  input  logic             ce,
  input  logic             cs_n,
  input  logic             short_mode,
  input  logic             cmp_below,
  output logic [NBITS-1:0] trial_code,
  output logic             sample_en,
  output logic             busy,
  output logic [NBITS-1:0] rd_data,
  output logic             rd_oe
);
  localparam int IW = $clog2(NBITS);

  phase_t           phase;
  logic             start;
  logic             decide;
  logic [IW-1:0]    bit_idx;
  logic [NBITS-1:0] result;

  sar_start_qual u_start (
    .clk   (clk),
    .rst_n (rst_n),
    .rc_n  (rc_n),
    .ce    (ce),
    .cs_n  (cs_n),
    .idle  (phase == PH_IDLE),
    .start (start)
  );

  sar_phase_seq #(
    .NBITS      (NBITS),
    .SHORT_BITS (SHORT_BITS),
    .ACQ_CYCLES (ACQ_CYCLES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .short_mode (short_mode),
    .phase      (phase),
    .bit_idx    (bit_idx),
    .decide     (decide)
  );

  sar_trial_reg #(.NBITS(NBITS)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start),
    .decide     (decide),
    .bit_idx    (bit_idx),
    .cmp_below  (cmp_below),
    .result     (result),
    .trial_code (trial_code)
  );

  assign busy      = (phase != PH_IDLE);
  assign sample_en = (phase == PH_ACQ);
  assign rd_oe     = ce & ~cs_n & rc_n & ~busy;
  assign rd_data   = rd_oe ? result : '0;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int NBITS      = 12,
  parameter int ACQ_CYCLES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rc_n,
  input logic             ce,
  input logic             cs_n,
  input logic             busy,
  input logic             sample_en,
  input logic             rd_oe,
  input logic [NBITS-1:0] trial_code
);
  localparam int MAXLEN = NBITS + ACQ_CYCLES;
  localparam int CW     = $clog2(MAXLEN + 2);

  logic [CW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + CW'(1);
    else           run_len <= '0;
  end

  assert_start_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(ce) && !$past(cs_n) && !$past(rc_n)));

  assert_cleared_on_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> (trial_code == '0));

  assert_sample_in_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> busy);

  assert_sample_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sample_en);

  assert_len_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= CW'(MAXLEN));

  assert_bus_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_oe);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(trial_code));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.NBITS(NBITS), .ACQ_CYCLES(ACQ_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rc_n       (rc_n),
  .ce         (ce),
  .cs_n       (cs_n),
  .busy       (busy),
  .sample_en  (sample_en),
  .rd_oe      (rd_oe),
  .trial_code (trial_code)
);

// File: tb/sar_conv_ctrl_test.sv
module sar_conv_ctrl_test;
  localparam int TCK = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rc_n = 1'b1;
  logic        ce = 1'b1;
  logic        cs_n = 1'b0;
  logic        short_mode = 1'b0;
  logic        cmp_below;
  logic [11:0] trial_code;
  logic        sample_en;
  logic        busy;
  logic [11:0] rd_data;
  logic        rd_oe;
  logic [11:0] vin = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(TCK/2) clk = ~clk;

  // Ideal comparator: trial level at or below the input keeps the bit.
  assign cmp_below = (trial_code <= vin);

  sar_conv_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rc_n       (rc_n),
    .ce         (ce),
    .cs_n       (cs_n),
    .short_mode (short_mode),
    .cmp_below  (cmp_below),
    .trial_code (trial_code),
    .sample_en  (sample_en),
    .busy       (busy),
    .rd_data    (rd_data),
    .rd_oe      (rd_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Runs one conversion; optionally wiggles rc_n mid-conversion (R7).
  task automatic convert(input logic [11:0] v, input logic sm, input bit retrig, input bit detail);
    int len;
    vin = v;
    short_mode = sm;
    rc_n = 1'b0;
    len = 0;
    @(negedge clk);
    while (busy && len < 40) begin
      len++;
      if (detail) begin
        check("R3 sample_en", int'(sample_en), (len <= 2) ? 1 : 0);
        if (len <= 2) check("R2 cleared", int'(trial_code), 0);
        if (len == 3) check("R4 first trial", int'(trial_code), 12'h800);
        check("R8 blocked", int'(rd_oe), 0);
      end
      if (retrig && len == 4) rc_n = 1'b1;
      if (retrig && len == 6) rc_n = 1'b0;
      @(negedge clk);
    end
    check(sm ? "R6 length" : (retrig ? "R7 length" : "R5 length"), len, sm ? 10 : 14);
    rc_n = 1'b1;
    #1;
    check("R8 read enable", int'(rd_oe), 1);
    check(sm ? "R6 result" : (retrig ? "R7 result" : "R4 result"),
          int'(rd_data), sm ? int'(v & 12'hFF0) : int'(v));
    @(negedge clk);
  endtask

  initial begin
    #(TCK * 200000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state.
    check("R9 busy", int'(busy), 0);
    check("R9 sample_en", int'(sample_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 result", int'(rd_data), 0);
    check("R9 oe", int'(rd_oe), 1);

    // R1: falling edge without enables is ignored.
    ce = 1'b0;
    rc_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 ce low", int'(busy), 0);
    rc_n = 1'b1; ce = 1'b1; @(negedge clk);
    cs_n = 1'b1;
    rc_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 cs high", int'(busy), 0);
    rc_n = 1'b1; cs_n = 1'b0; @(negedge clk);

    // Detailed conversions on corner codes.
    convert(12'h000, 1'b0, 1'b0, 1'b1);
    convert(12'hFFF, 1'b0, 1'b0, 1'b1);
    convert(12'h800, 1'b0, 1'b0, 1'b1);
    convert(12'h7FF, 1'b1, 1'b0, 1'b1);

    // R7: retrigger edges during a conversion.
    convert(12'hA5C, 1'b0, 1'b1, 1'b0);
    convert(12'h3C3, 1'b1, 1'b1, 1'b0);

    // R8/R10: gating by each enable, result held across reads.
    ce = 1'b0; #1;
    check("R8 ce gate oe", int'(rd_oe), 0);
    check("R8 ce gate data", int'(rd_data), 0);
    ce = 1'b1; cs_n = 1'b1; #1;
    check("R8 cs gate oe", int'(rd_oe), 0);
    cs_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R10 held", int'(rd_data), 12'h3C0);
    check("R10 held again", int'(rd_data), 12'h3C0);

    // Exhaustive 12-bit sweep (R4, R5).
    for (int v = 0; v < 4096; v++) convert(12'(v), 1'b0, 1'b0, 1'b0);
    // 8-bit sweep with varied low nibble (R6).
    for (int v = 0; v < 4096; v += 13) convert(12'(v), 1'b1, 1'b0, 1'b0);

    finished = 1'b1;
    summary();
  end
endmodule